// File: doc/BRIEF.md
# Write-once configurable watchdog timer

This block is a watchdog timer controlled by an 8-bit mode register. Software may write that register once after each reset. The register chooses the count source and the overflow period. The source is either an internal oscillator clock enable or a high-speed system clock enable, or the timer can be stopped. The period is one of eight powers of two. The counter advances on cycles where the selected source's clock-enable input is high and the source-running flag is set. Software clears the counter with a kick strobe. If the counter reaches the selected period before a kick arrives, the block raises a one-cycle reset request.

The register is protected in several ways. A second full-byte write after the first raises a reset request. If the count source is stopped when that second write arrives, the request waits and fires once the source runs again. Byte writes that are not full-width (single-bit manipulations) are rejected. A static lock input decides whether software may stop the timer. With the lock set, the internal oscillator clock is used whatever clock-select bits are written. With the lock clear, a write that stops the timer is final until the next reset, and a stopped timer never raises a reset request.

The controller has four states. OPEN is the state after reset: no write has been taken yet and the reset mode is active. ARMED means the one write has been taken and the timer runs. HALT means software stopped the timer, and only a reset leaves it. PEND means a forbidden rewrite arrived while the source was stopped. The transitions are:
- CFG_RUN: OPEN to ARMED, on a first full write that does not stop the timer.
- CFG_STOP: OPEN to HALT, on a first full write that stops the timer.
- REWRITE_FIRE: ARMED to ARMED, on a rewrite while the source runs. It fires a request.
- REWRITE_DEFER: ARMED to PEND, on a rewrite while the source is stopped.
- RESUME: PEND to ARMED, when the source runs again. It fires a request.

Top module: `wdt_writeonce`

## Requirements
- R1: After reset, `mode_rd` reads 0x67 and `rst_req` is low. In this state the timer counts internal-oscillator enables at period selector 7.
- R2: `mode_rd` always reads bits 7:5 as 011, whatever was written to them. Bits 4:3 hold the clock selection: 00 is the internal oscillator, 01 is the high-speed clock, and 1x is stop. Bits 2:0 hold the period selector n.
- R3: On the internal source, the terminal count is reached after 2^(BASE_INT+n) counting ticks. In the cycle after the terminal tick, `rst_req` is high for exactly one cycle, and the counter restarts from zero.
- R4: On the high-speed source, the terminal count is reached after 2^(BASE_HS+n) ticks of `ce_hs`.
- R5: A kick clears the counter. A kick takes priority over a terminal tick in the same cycle, so no request fires in that cycle.
- R6: The first full write is stored and clears the counter. A further full write while the source runs raises `rst_req` in the next cycle, and the stored mode does not change.
- R7: A further full write while `src_run` is low raises no request at that time. `rst_req` goes high in the cycle after the first cycle in which `src_run` is seen high.
- R8: With `opt_lock` high, the written clock-select bits 4:3 are stored as 00. The timer then counts `ce_int`.
- R9: With `opt_lock` low, a first write with bit 4 set stops the timer. After that, no count and no request ever happens, and later writes change nothing.
- R10: A write with `wr_full` low is ignored. It does not change the mode, it does not count as the first write, and it raises no request.
- R11: A tick needs both `src_run` and the enable of the selected source. The enable of the other source has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_lock | input | 1 | Static option: 1 means the timer cannot be stopped and the internal source is forced |
| wr_en | input | 1 | Mode register write strobe |
| wr_full | input | 1 | 1 for a full-byte write; 0 marks a rejected single-bit write |
| wr_data | input | 8 | Write data |
| kick | input | 1 | Counter clear strobe |
| ce_int | input | 1 | Internal oscillator clock enable |
| ce_hs | input | 1 | High-speed system clock enable |
| src_run | input | 1 | Selected count source is running |
| rst_req | output | 1 | One-cycle internal reset request |
| mode_rd | output | 8 | Mode register read value |

## Verification
Each result has a fixed due time. A write changes `mode_rd` right after the rising edge that samples it. A request caused by a terminal tick, a rewrite or a resume shows on `rst_req` after the edge that samples its cause, with no further delay. The bench drives inputs on falling edges. A behavioural model advances at every rising edge, and `rst_req` and `mode_rd` are compared with it 1 ns after that edge, so every compare falls in the cycle the result is due. Per-phase pulse counts then confirm the overflow periods, the deferred request and the silence of a stopped timer.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HALT  = 2'd2,
        ST_PEND  = 2'd3
    } wdt_state_e;

    // Stored part of the mode register (bits 4:0)
    typedef struct packed {
        logic       halt;   // bit 4
        logic       hs;     // bit 3
        logic [2:0] sel;    // bits 2:0
    } wdt_mode_t;

    localparam wdt_mode_t MODE_RST  = '{halt: 1'b0, hs: 1'b0, sel: 3'd7};
    localparam logic [2:0] FIXED_TOP = 3'b011;

    // Apply the lock option to written data
    function automatic wdt_mode_t shape_mode(input logic [4:0] d, input logic lock);
        wdt_mode_t m;
        m.sel  = d[2:0];
        m.hs   = d[3] & ~lock;
        m.halt = d[4] & ~lock;
        return m;
    endfunction

endpackage

// File: rtl/wdt_mode_ctl.sv
module wdt_mode_ctl
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       opt_lock,
    input  logic       wr_en,
    input  logic       wr_full,
    input  logic [4:0] wr_low,
    input  logic       src_run,
    output wdt_mode_t  mode_q,
    output wdt_state_e st_q,
    output logic       cfg_load,
    output logic       refire
);

    wdt_state_e st_d;
    wdt_mode_t  mode_d;
    wdt_mode_t  shaped;
    logic       full_wr;

    assign full_wr = wr_en & wr_full;
    assign shaped  = shape_mode(wr_low, opt_lock);

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        unique case (st_q)
            ST_OPEN: begin
                if (full_wr) begin
                    mode_d = shaped;
                    st_d   = shaped.halt ? ST_HALT : ST_ARMED;   // CFG_STOP / CFG_RUN
                end
            end
            ST_ARMED: begin
                if (full_wr && !src_run) begin
                    st_d = ST_PEND;                              // REWRITE_DEFER
                end
            end
            ST_PEND: begin
                if (src_run) begin
                    st_d = ST_ARMED;                             // RESUME
                end
            end
            ST_HALT: begin
                st_d = ST_HALT;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OPEN;
            mode_q <= MODE_RST;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
        end
    end

    // Outputs
    always_comb begin
        cfg_load = 1'b0;
        refire   = 1'b0;
        unique case (st_q)
            ST_OPEN:  cfg_load = full_wr;
            ST_ARMED: refire   = full_wr & src_run;              // REWRITE_FIRE
            ST_PEND:  refire   = src_run;                        // RESUME
            ST_HALT:  refire   = 1'b0;
        endcase
    end

    // R6: once configured, never back to OPEN before reset
    p_open_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OPEN) |=> (st_q != ST_OPEN));

    // R9: a stopped timer stays stopped with its mode frozen
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |=> (st_q == ST_HALT) && $stable(mode_q));

    // R8: locked option keeps the internal source
    p_lock_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_lock && st_q != ST_OPEN) |-> (!mode_q.halt && !mode_q.hs));

    // R10: a partial write leaves the mode untouched
    p_partial_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_full) |=> $stable(mode_q));

    // R7: a pending request leaves PEND when the source runs
    p_pend_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && src_run) |=> (st_q == ST_ARMED));

endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_pkg::*;
#(
    parameter int BASE_INT = 11,
    parameter int BASE_HS  = 13,
    parameter int EW       = 5
) (
    input  wdt_mode_t        mode,
    input  wdt_state_e       st,
    input  logic             ce_int,
    input  logic             ce_hs,
    input  logic             src_run,
    output logic             tick,
    output logic [EW-1:0]    expo
);

    localparam logic [EW-1:0] E_INT = EW'(BASE_INT);
    localparam logic [EW-1:0] E_HS  = EW'(BASE_HS);

    logic active;
    logic ce_sel;

    assign active = (st != ST_HALT) & ~mode.halt;
    assign ce_sel = mode.hs ? ce_hs : ce_int;
    assign tick   = active & src_run & ce_sel;
    assign expo   = (mode.hs ? E_HS : E_INT) + EW'(mode.sel);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CW = 20,
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic [EW-1:0] expo,
    output logic          ovf
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          at_lim;

    // Terminal value: expo low bits set
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            lim[i] = (i < int'(expo));
        end
    end

    assign at_lim = (cnt_q == lim);
    assign ovf    = tick & ~clear & at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_lim ? '0 : cnt_q + CW'(1);
        end
    end

    // R3: counter never passes the terminal value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    // R5: a clear always lands the counter at zero
    p_kick_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_writeonce.sv
module wdt_writeonce
    import wdt_pkg::*;
#(
    parameter int BASE_INT = 11,
    parameter int BASE_HS  = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       opt_lock,
    input  logic       wr_en,
    input  logic       wr_full,
    input  logic [7:0] wr_data,
    input  logic       kick,
    input  logic       ce_int,
    input  logic       ce_hs,
    input  logic       src_run,
    output logic       rst_req,
    output logic [7:0] mode_rd
);

    localparam int EMAX = ((BASE_HS > BASE_INT) ? BASE_HS : BASE_INT) + 7;
    localparam int CW   = EMAX;
    localparam int EW   = $clog2(EMAX + 1);

    wdt_mode_t     mode_q;
    wdt_state_e    st_q;
    logic          cfg_load;
    logic          refire;
    logic          tick;
    logic [EW-1:0] expo;
    logic          ovf;
    logic          clr;
    logic          rst_req_q;
    logic          unused_top;

    assign unused_top = ^wr_data[7:5];

    wdt_mode_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opt_lock (opt_lock),
        .wr_en    (wr_en),
        .wr_full  (wr_full),
        .wr_low   (wr_data[4:0]),
        .src_run  (src_run),
        .mode_q   (mode_q),
        .st_q     (st_q),
        .cfg_load (cfg_load),
        .refire   (refire)
    );

    wdt_tick_sel #(.BASE_INT(BASE_INT), .BASE_HS(BASE_HS), .EW(EW)) u_sel (
        .mode    (mode_q),
        .st      (st_q),
        .ce_int  (ce_int),
        .ce_hs   (ce_hs),
        .src_run (src_run),
        .tick    (tick),
        .expo    (expo)
    );

    assign clr = kick | cfg_load | refire;

    wdt_counter #(.CW(CW), .EW(EW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clear (clr),
        .expo  (expo),
        .ovf   (ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= ovf | refire;
        end
    end

    assign rst_req = rst_req_q;
    assign mode_rd = {FIXED_TOP, mode_q};

    // R9: a stopped timer never requests a reset
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |=> !rst_req_q);

    // R7: a deferred rewrite fires once the source runs
    p_pend_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && src_run) |=> rst_req_q);

    // R6: rewrite with a running source fires next cycle
    p_rewrite_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && wr_en && wr_full && src_run) |=> rst_req_q);

endmodule

// File: tb/sim_wdt_writeonce.sv
module sim_wdt_writeonce;

    localparam int BI = 3;
    localparam int BH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_lock = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_full = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       kick = 1'b0;
    logic       ce_int = 1'b1;
    logic       ce_hs = 1'b0;
    logic       src_run = 1'b1;
    logic       rst_req;
    logic [7:0] mode_rd;

    always #10 clk = ~clk;

    wdt_writeonce #(.BASE_INT(BI), .BASE_HS(BH)) u0 (
        .clk(clk), .rst_n(rst_n), .opt_lock(opt_lock), .wr_en(wr_en),
        .wr_full(wr_full), .wr_data(wr_data), .kick(kick), .ce_int(ce_int),
        .ce_hs(ce_hs), .src_run(src_run), .rst_req(rst_req), .mode_rd(mode_rd)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    pulses = 0;
    bit    done = 1'b0;
    string phase = "R1";

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int         m_st;     // 0 open, 1 armed, 2 halt, 3 pend
    int         m_cnt;
    logic [4:0] m_mode;
    logic       m_req;

    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_mode = 5'b00111; m_cnt = 0; m_req = 1'b0;
        end else begin
            int e;
            logic tk, clr, fire, full;
            logic [4:0] nm;
            full = wr_en && wr_full;
            fire = 1'b0;
            clr  = kick;
            tk   = (m_st != 2) && src_run && (m_mode[3] ? ce_hs : ce_int);
            e    = (m_mode[3] ? BH : BI) + int'(m_mode[2:0]);
            case (m_st)
                0: if (full) begin
                       nm = wr_data[4:0];
                       if (opt_lock) nm[4:3] = 2'b00;
                       m_mode = nm;
                       m_st = nm[4] ? 2 : 1;
                       clr = 1'b1;
                   end
                1: if (full) begin
                       if (src_run) fire = 1'b1; else m_st = 3;
                   end
                3: if (src_run) begin fire = 1'b1; m_st = 1; end
                default: ;
            endcase
            if (fire) clr = 1'b1;
            if (clr) m_cnt = 0;
            else if (tk) begin
                if (m_cnt == (1 << e) - 1) begin fire = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end
            m_req = fire;
        end
        #1;
        if (!done) begin
            chk(phase, int'(rst_req), int'(m_req));
            chk(phase, int'(mode_rd), int'({3'b011, m_mode}));
            if (rst_n && rst_req) pulses++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic full);
        @(negedge clk);
        wr_en = 1'b1; wr_full = full; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_full = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic do_reset(input logic lock);
        @(negedge clk);
        rst_n = 1'b0; opt_lock = lock;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(1'b1);
        phase = "R1";
        step(1);
        chk("R1", int'(mode_rd), 'h67);
        chk("R1", int'(rst_req), 0);

        phase = "R10";
        wr(8'h1A, 1'b0);
        step(2);
        chk("R10", int'(mode_rd), 'h67);

        phase = "R5";
        pulses = 0;
        for (int i = 0; i < 4; i++) begin
            step(600);
            pulse_kick();
        end
        chk("R5", pulses, 0);

        phase = "R3";
        pulses = 0;
        step(1030);
        chk("R3", pulses, 1);

        phase = "R11";
        pulses = 0;
        ce_int = 1'b0; ce_hs = 1'b1;
        step(1500);
        ce_int = 1'b1; src_run = 1'b0;
        step(1500);
        src_run = 1'b1;
        chk("R11", pulses, 0);

        phase = "R8";
        ce_int = 1'b1; ce_hs = 1'b1;
        wr(8'h1A, 1'b1);
        chk("R8", int'(mode_rd), 'h62);
        pulses = 0;
        step(70);
        chk("R8", pulses, 2);

        phase = "R6";
        pulses = 0;
        wr(8'h07, 1'b1);
        step(2);
        chk("R6", pulses, 1);
        chk("R6", int'(mode_rd), 'h62);

        do_reset(1'b0);
        phase = "R2";
        wr(8'hE9, 1'b1);
        chk("R2", int'(mode_rd), 'h69);
        phase = "R4";
        pulses = 0;
        step(100);
        chk("R4", pulses, 3);

        phase = "R7";
        pulses = 0;
        src_run = 1'b0;
        wr(8'h00, 1'b1);
        step(5);
        chk("R7", pulses, 0);
        src_run = 1'b1;
        step(2);
        chk("R7", pulses, 1);

        do_reset(1'b0);
        phase = "R9";
        wr(8'h10, 1'b1);
        chk("R9", int'(mode_rd), 'h70);
        pulses = 0;
        step(2000);
        wr(8'h03, 1'b1);
        step(3);
        chk("R9", pulses, 0);
        chk("R9", int'(mode_rd), 'h70);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule